// File: doc/BRIEF.md
# Multi-Sector BCH8 Parity Encoder

This block computes the parity of a binary BCH code that corrects up to eight bit errors per 512-byte NAND sector. Sector data is streamed in one byte per clock through a strobed byte input. The block divides the data polynomial, shifted by the code's degree, by a fixed degree-104 generator over GF(2^13). It keeps a separate 104-bit remainder for each of up to eight consecutive sectors of one run.

A run is armed with a three-bit sector count (value plus one sectors) and started by raising the enable input. The block walks through the sector slots on its own and raises `done` after the last byte of the last sector. A clear pulse wipes every stored remainder before the next run. A read port selects a sector and a byte index and returns one of thirteen parity bytes. Each parity byte is XORed with a fixed constant, so an erased sector of all 0xFF reads back as all 0xFF.

The sequencer has four states. IDLE waits after reset or clear. RUN accepts bytes. PAUSE holds the position while enable is low. DONE holds the final results. The transitions are:
- IDLE to RUN when enable is high.
- RUN to PAUSE when enable drops.
- PAUSE to RUN when enable returns.
- RUN to DONE on the final accepted byte.
- Any state to IDLE on clear.

Top module: `bch8_sector_encoder`

## Requirements
- R1: The parity of a sector is the remainder of D(x)·x^104 modulo g(x). D(x) has the first byte's bit 7 as its highest-order term, with bits taken most significant first within each byte. g(x) is the product of the minimal polynomials of alpha^1, alpha^3, …, alpha^15 in GF(2^13), built with field polynomial 0x201B.
- R2: Read byte k (0 to 12) returns remainder bits [103-8k : 96-8k] XOR the k-th constant of EF 51 2E 09 ED 93 9A C2 97 79 E5 24 B5. Byte indices 13 to 15 read 0x00.
- R3: A run covers `sect_last`+1 sectors, with the value latched on the IDLE to RUN move. Each sector keeps its own result in slot 0, 1, … in arrival order, and `done` stays low until the last of them is finished.
- R4: After the 512th accepted byte of a sector, the next byte goes to the next slot, and that slot's remainder starts from zero.
- R5: `done` rises in the cycle after the last byte of the final sector is accepted. While in DONE, further input bytes leave every result unchanged.
- R6: A byte is accepted only in RUN with enable high. Bytes offered with enable low are ignored. When enable returns, the block moves PAUSE to RUN in one cycle and resumes at the same byte position.
- R7: After reset or a clear pulse, every remainder is zero (reads return the bare constants), `done` is low and the position is sector 0, byte 0. Clear takes priority over a byte offered in the same cycle.
- R8: A sector of 512 bytes of 0xFF reads back as 13 bytes of 0xFF.
- R9: Reading a sector part-way through returns the masked remainder of the bytes accepted so far.
- R10: An erased sector with one data bit p flipped (bit p mod 8 of byte p/8, p < 4096) gives parity that matches R1 and is not all 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_enable | input | 1 | Level: run accumulation while high |
| ecc_clear | input | 1 | Pulse: zero all remainders, return to IDLE |
| sect_last | input | 3 | Number of sectors in the run minus one |
| din | input | 8 | Sector data byte |
| din_valid | input | 1 | Data byte strobe |
| rd_sector | input | 3 | Result read: sector slot |
| rd_byte | input | 4 | Result read: parity byte index |
| rd_data | output | 8 | Masked parity byte |
| done | output | 1 | All sectors of the run finished |

## Verification
The bench builds the block with its defaults: 512-byte sectors and eight slots. This makes the full-length sector boundary, the advance through every slot and the maximum sector count reachable. Random sector data is checked against a bit-serial division model. That model uses a generator the bench derives by multiplying all 104 root factors directly. Directed runs cover erased sectors, single-bit flips, a pause mid-sector, a clear mid-run and input arriving after completion.

// File: rtl/bch8_pkg.sv
package bch8_pkg;

    localparam int GF_M      = 13;
    localparam logic [GF_M:0] GF_POLY = 14'h201B;
    localparam int BCH_T     = 8;
    localparam int PAR_BITS  = GF_M * BCH_T;
    localparam int PAR_BYTES = PAR_BITS / 8;

    // Index k holds the constant applied to output byte k.
    localparam logic [PAR_BYTES-1:0][7:0] ERASE_MASK = {
        8'hB5, 8'h24, 8'hE5, 8'h79, 8'h97, 8'hC2, 8'h9A,
        8'h93, 8'hED, 8'h09, 8'h2E, 8'h51, 8'hEF
    };

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_DONE
    } seq_state_t;

    function automatic logic [GF_M-1:0] gf_xtime(input logic [GF_M-1:0] a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_POLY[GF_M-1:0] : '0);
    endfunction

    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] p;
        logic [GF_M-1:0] x;
        p = '0;
        x = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) p = p ^ x;
            x = gf_xtime(x);
        end
        return p;
    endfunction

    // Product of the minimal polynomials of alpha^1, alpha^3 .. alpha^(2T-1).
    function automatic logic [PAR_BITS:0] bch_gen_poly();
        logic [PAR_BITS:0]           g;
        logic [PAR_BITS:0]           acc;
        logic [GF_M:0][GF_M-1:0]     mp;
        logic [GF_M-1:0]             beta;
        g    = '0;
        g[0] = 1'b1;
        for (int i = 1; i < 2 * BCH_T; i += 2) begin
            beta = GF_M'(1);
            for (int e = 0; e < i; e++) beta = gf_xtime(beta);
            mp    = '0;
            mp[0] = GF_M'(1);
            for (int j = 0; j < GF_M; j++) begin
                for (int k = GF_M; k > 0; k--)
                    mp[k] = mp[k-1] ^ gf_mul(mp[k], beta);
                mp[0] = gf_mul(mp[0], beta);
                beta  = gf_mul(beta, beta);
            end
            acc = '0;
            for (int k = 0; k <= GF_M; k++)
                if (mp[k][0]) acc = acc ^ (g << k);
            g = acc;
        end
        return g;
    endfunction

endpackage

// File: rtl/bch_lfsr_step.sv
module bch_lfsr_step
    import bch8_pkg::*;
(
    input  logic [PAR_BITS-1:0] rem_in,
    input  logic [7:0]          din,
    output logic [PAR_BITS-1:0] rem_out
);

    localparam logic [PAR_BITS:0] GEN = bch_gen_poly();

    logic [PAR_BITS-1:0] r;
    logic                fb;

    // Eight division steps unrolled, most significant data bit first.
    always_comb begin
        r  = rem_in;
        fb = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            fb = r[PAR_BITS-1] ^ din[b];
            r  = {r[PAR_BITS-2:0], 1'b0} ^ (fb ? GEN[PAR_BITS-1:0] : '0);
        end
        rem_out = r;
    end

endmodule

// File: rtl/bch_seq_ctrl.sv
module bch_seq_ctrl
    import bch8_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int SLOTS      = 8,
    localparam int BYTE_W    = $clog2(SECT_BYTES),
    localparam int SLOT_W    = $clog2(SLOTS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              enable,
    input  logic [SLOT_W-1:0] cnt_m1,
    input  logic              valid,
    output logic              wr_en,
    output logic [SLOT_W-1:0] slot,
    output logic              done
);

    seq_state_t        state_q, state_d;
    logic [BYTE_W-1:0] byte_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] last_q;
    logic              last_byte;

    assign last_byte = (byte_q == BYTE_W'(SECT_BYTES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable) state_d = ST_RUN;
            ST_RUN: begin
                if (!enable)
                    state_d = ST_PAUSE;
                else if (valid && last_byte && (slot_q == last_q))
                    state_d = ST_DONE;
            end
            ST_PAUSE: if (enable) state_d = ST_RUN;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    always_comb begin
        wr_en = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_RUN:  wr_en = enable && valid && !clr;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
        slot = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            slot_q <= '0;
            last_q <= '0;
        end else if (clr) begin
            byte_q <= '0;
            slot_q <= '0;
        end else begin
            if ((state_q == ST_IDLE) && enable) last_q <= cnt_m1;
            if (wr_en) begin
                if (last_byte) begin
                    byte_q <= '0;
                    if (slot_q != last_q) slot_q <= slot_q + 1'b1;
                end else begin
                    byte_q <= byte_q + 1'b1;
                end
            end
        end
    end

    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last_byte && (slot_q != last_q)) |=>
        ((slot_q == SLOT_W'($past(slot_q) + 1'b1)) && (byte_q == '0))); // R4

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (slot_q <= last_q)); // R3

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE) && !clr) |=> (state_q == ST_DONE)); // R5

    AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((state_q == ST_IDLE) && (byte_q == '0) && (slot_q == '0))); // R7

endmodule

// File: rtl/bch_rem_bank.sv
module bch_rem_bank
    import bch8_pkg::*;
#(
    parameter int SLOTS   = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int RD_W   = $clog2(PAR_BYTES)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic [PAR_BITS-1:0] wr_rem,
    output logic [PAR_BITS-1:0] cur_rem,
    input  logic [SLOT_W-1:0]   rd_slot,
    input  logic [RD_W-1:0]     rd_byte,
    output logic [7:0]          rd_data
);

    logic [SLOTS-1:0][PAR_BITS-1:0] bank_q;
    logic [PAR_BITS-1:0]            sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bank_q <= '0;
        else if (clr)   bank_q <= '0;
        else if (wr_en) bank_q[wr_slot] <= wr_rem;
    end

    assign cur_rem = bank_q[wr_slot];

    // Byte 0 carries the highest-order remainder bits.
    always_comb begin
        sel     = bank_q[rd_slot];
        rd_data = 8'h00;
        for (int k = 0; k < PAR_BYTES; k++)
            if (rd_byte == RD_W'(k))
                rd_data = sel[PAR_BITS-1-8*k -: 8] ^ ERASE_MASK[k];
    end

    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(bank_q)); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bank_q == '0)); // R7

endmodule

// File: rtl/bch8_sector_encoder.sv
module bch8_sector_encoder
    import bch8_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int SLOTS      = 8,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int RD_W      = $clog2(PAR_BYTES)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_enable,
    input  logic              ecc_clear,
    input  logic [SLOT_W-1:0] sect_last,
    input  logic [7:0]        din,
    input  logic              din_valid,
    input  logic [SLOT_W-1:0] rd_sector,
    input  logic [RD_W-1:0]   rd_byte,
    output logic [7:0]        rd_data,
    output logic              done
);

    logic                wr_en;
    logic [SLOT_W-1:0]   slot;
    logic [PAR_BITS-1:0] cur_rem;
    logic [PAR_BITS-1:0] nxt_rem;

    bch_seq_ctrl #(
        .SECT_BYTES (SECT_BYTES),
        .SLOTS      (SLOTS)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ecc_clear),
        .enable (ecc_enable),
        .cnt_m1 (sect_last),
        .valid  (din_valid),
        .wr_en  (wr_en),
        .slot   (slot),
        .done   (done)
    );

    bch_lfsr_step u_step (
        .rem_in  (cur_rem),
        .din     (din),
        .rem_out (nxt_rem)
    );

    bch_rem_bank #(
        .SLOTS (SLOTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ecc_clear),
        .wr_en   (wr_en),
        .wr_slot (slot),
        .wr_rem  (nxt_rem),
        .cur_rem (cur_rem),
        .rd_slot (rd_sector),
        .rd_byte (rd_byte),
        .rd_data (rd_data)
    );

    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(din_valid && ecc_enable)); // R5

endmodule

// File: tb/bch8_sector_encoder_bench.sv
module bch8_sector_encoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SB         = 512;
    localparam int NS         = 8;
    localparam int WDOG       = 150000;
    localparam logic [12:0][7:0] MASK = {
        8'hB5, 8'h24, 8'hE5, 8'h79, 8'h97, 8'hC2, 8'h9A,
        8'h93, 8'hED, 8'h09, 8'h2E, 8'h51, 8'hEF
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ecc_enable = 1'b0;
    logic       ecc_clear = 1'b0;
    logic [2:0] sect_last = '0;
    logic [7:0] din = '0;
    logic       din_valid = 1'b0;
    logic [2:0] rd_sector = '0;
    logic [3:0] rd_byte = '0;
    logic [7:0] rd_data;
    logic       done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0]   mem [0:NS*SB-1];
    logic [104:0] gen;

    bch8_sector_encoder u_bch8_sector_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_enable (ecc_enable),
        .ecc_clear  (ecc_clear),
        .sect_last  (sect_last),
        .din        (din),
        .din_valid  (din_valid),
        .rd_sector  (rd_sector),
        .rd_byte    (rd_byte),
        .rd_data    (rd_data),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<%0d", cyc, WDOG);
            summary();
        end
    end

    // Field arithmetic written independently: full product then reduction.
    function automatic logic [12:0] tmul(input logic [12:0] a, input logic [12:0] b);
        logic [24:0] p;
        p = '0;
        for (int k = 0; k < 13; k++) if (b[k]) p = p ^ (25'(a) << k);
        for (int k = 24; k >= 13; k--) if (p[k]) p = p ^ (25'(14'h201B) << (k - 13));
        return p[12:0];
    endfunction

    function automatic logic [12:0] talpha(input int e);
        logic [12:0] v;
        v = 13'd1;
        for (int n = 0; n < e; n++) v = tmul(v, 13'd2);
        return v;
    endfunction

    // Generator as the product of all 104 linear root factors.
    function automatic logic [104:0] tgen();
        logic [104:0][12:0] p;
        logic [104:0]       g;
        logic [12:0]        r;
        int                 deg;
        p = '0; p[0] = 13'd1; deg = 0;
        for (int i = 1; i < 16; i += 2) begin
            for (int j = 0; j < 13; j++) begin
                r = talpha((i << j) % 8191);
                for (int k = deg + 1; k > 0; k--) p[k] = p[k-1] ^ tmul(p[k], r);
                p[0] = tmul(p[0], r);
                deg++;
            end
        end
        for (int k = 0; k <= 104; k++) g[k] = p[k][0];
        return g;
    endfunction

    // Bit-serial division of the first n bytes of a sector.
    function automatic logic [103:0] ref_rem(input int sec, input int n);
        logic [103:0] r;
        logic [7:0]   d;
        logic         fb;
        r = '0;
        for (int i = 0; i < n; i++) begin
            d = mem[sec*SB + i];
            for (int b = 7; b >= 0; b--) begin
                fb = r[103] ^ d[b];
                r  = r << 1;
                if (fb) r = r ^ gen[103:0];
            end
        end
        return r;
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chkbit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_sector(input int sec, input int n, input string req);
        logic [103:0] r;
        r = ref_rem(sec, n);
        for (int k = 0; k < 13; k++) begin
            rd_sector = 3'(sec);
            rd_byte   = 4'(k);
            #1;
            chk8(req, rd_data, r[103-8*k -: 8] ^ MASK[k]);
        end
    endtask

    task automatic check_all_ff(input int sec, input string req);
        for (int k = 0; k < 13; k++) begin
            rd_sector = 3'(sec);
            rd_byte   = 4'(k);
            #1;
            chk8(req, rd_data, 8'hFF);
        end
    endtask

    task automatic feed(input int sec, input int from, input int upto, input int gap_pct);
        for (int i = from; i < upto; i++) begin
            while (($urandom % 100) < gap_pct) begin
                din_valid = 1'b0;
                din = 8'($urandom);
                @(negedge clk);
            end
            din = mem[sec*SB + i];
            din_valid = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
    endtask

    task automatic do_clear();
        ecc_enable = 1'b0;
        ecc_clear = 1'b1;
        din = 8'h5A;
        din_valid = 1'b1;
        @(negedge clk);
        ecc_clear = 1'b0;
        din_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_run(input int count);
        sect_last = 3'(count - 1);
        ecc_enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic         any_diff;
        int           p;
        void'($urandom(32'd20240611));
        gen = tgen();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R7
        chkbit("R7 done after reset", done, 1'b0);
        check_sector(0, 0, "R7 reset reads constants");

        // Erased single sector: R8, R5
        for (int i = 0; i < SB; i++) mem[i] = 8'hFF;
        start_run(1);
        feed(0, 0, SB, 10);
        chkbit("R5 done after single sector", done, 1'b1);
        check_all_ff(0, "R8 erased sector");

        // Clear: R7
        do_clear();
        chkbit("R7 done after clear", done, 1'b0);
        check_sector(0, 0, "R7 clear zeroes slot 0");

        // Eight random sectors with pause and partial reads: R1 R2 R3 R4 R6 R9
        for (int i = 0; i < NS*SB; i++) mem[i] = 8'($urandom);
        start_run(8);
        feed(0, 0, 100, 20);
        check_sector(0, 100, "R9 partial read");
        feed(0, 100, SB, 20);
        for (int s = 1; s < NS; s++) begin
            if (s == 3) begin
                feed(3, 0, 200, 20);
                ecc_enable = 1'b0;
                for (int j = 0; j < 20; j++) begin
                    din = 8'($urandom);
                    din_valid = 1'b1;
                    @(negedge clk);
                end
                din_valid = 1'b0;
                check_sector(3, 200, "R6 paused bytes ignored");
                ecc_enable = 1'b1;
                @(negedge clk);
                feed(3, 200, SB, 20);
            end else begin
                feed(s, 0, SB, 20);
            end
            if (s == NS - 2) chkbit("R3 done low before last sector", done, 1'b0);
        end
        chkbit("R5 done after eight sectors", done, 1'b1);
        for (int s = 0; s < NS; s++) check_sector(s, SB, "R1 R4 sector parity");
        rd_sector = 3'd2; rd_byte = 4'd13; #1;
        chk8("R2 byte index 13", rd_data, 8'h00);
        rd_byte = 4'd15; #1;
        chk8("R2 byte index 15", rd_data, 8'h00);
        ecc_enable = 1'b1;
        for (int j = 0; j < 6; j++) begin
            din = 8'($urandom);
            din_valid = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        check_sector(7, SB, "R5 input after done ignored");
        chkbit("R5 done holds", done, 1'b1);

        // Clear mid-run then a three-sector run: R7 R10 R3
        do_clear();
        start_run(2);
        feed(0, 0, 300, 0);
        do_clear();
        chkbit("R7 done low after mid-run clear", done, 1'b0);
        check_sector(0, 0, "R7 mid-run clear");
        p = $urandom % 4096;
        for (int i = 0; i < SB; i++) mem[i] = 8'hFF;
        mem[p/8][p%8] = 1'b0;
        for (int i = SB; i < 2*SB; i++) mem[i] = 8'($urandom);
        for (int i = 2*SB; i < 3*SB; i++) mem[i] = 8'hFF;
        start_run(3);
        feed(0, 0, SB, 5);
        feed(1, 0, SB, 5);
        chkbit("R3 done low after two of three", done, 1'b0);
        feed(2, 0, SB, 5);
        chkbit("R3 done after three sectors", done, 1'b1);
        check_sector(0, SB, "R10 single-bit flip parity");
        any_diff = 1'b0;
        for (int k = 0; k < 13; k++) begin
            rd_sector = 3'd0; rd_byte = 4'(k); #1;
            if (rd_data != 8'hFF) any_diff = 1'b1;
        end
        chkbit("R10 flip differs from erased", any_diff, 1'b1);
        check_sector(1, SB, "R1 random sector");
        check_all_ff(2, "R8 erased third sector");

        // Flip at the last data bit position
        do_clear();
        for (int i = 0; i < SB; i++) mem[i] = 8'hFF;
        mem[511][7] = 1'b0;
        start_run(1);
        feed(0, 0, SB, 0);
        check_sector(0, SB, "R10 flip at bit 4095");

        summary();
    end

endmodule